// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ready-to-Send Flow Control

This block receives characters from an asynchronous serial line. An external baud generator supplies a one-cycle tick at sixteen times the bit rate. On each tick the receiver watches the synchronised line for a high-to-low transition. It confirms the start bit at mid-bit and then samples each following bit at its centre with a three-sample majority vote. It assembles seven- or eight-bit characters in either bit order, checks an optional even or odd parity bit and one or two stop bits, and then moves the character into a holding register.

The holding register has a receive-complete flag, an interrupt request and three error flags: parity, framing and overrun. A one-cycle read strobe tells the block that the host has taken the character, and this clears the complete flag and the error flags. The interrupt request is cleared separately, by an acknowledge pulse or by a software clear pulse. The ready-to-send output is low while the receiver can take a new character. It goes high once a start bit is confirmed and stays high until the held character has been read.

Configuration inputs are expected to stay stable while a character is being received.

Top module: `serial_rx_flow`

## Requirements
- R1: While `rx_en` is 0, falling edges on `rxd` start no reception. Dropping `rx_en` during a character abandons it, so `rx_done` stays 0.
- R2: The line is synchronised and examined on ticks only. A falling edge seen between two consecutive ticks begins a character, and that tick counts as tick 0 of the start bit. Every bit is decided by a majority of the samples taken at ticks 7, 8 and 9 of its 16.
- R3: If the start bit votes high at mid-bit, the event is a glitch. The receiver returns to idle, sets no flag and leaves `rts` unchanged.
- R4: A character consists of a low start bit, then 8 data bits when `cfg_len8`=1 or 7 data bits when `cfg_len8`=0, then a parity bit when `cfg_par_en`=1, then one stop bit, or two stop bits when `cfg_two_stop`=1.
- R5: When `cfg_msb_first`=1 and `cfg_len8`=1, the first data bit on the line is `rx_data[7]`. In every other case the first data bit is `rx_data[0]`. A 7-bit character appears in `rx_data[6:0]`, with `rx_data[7]`=0.
- R6: At the mid-point of the last stop bit, the character is written to `rx_data` and `rx_done` goes to 1 on the next cycle.
- R7: `irq_req` is set when a character is written. It is cleared by an `irq_ack` pulse or an `irq_clr` pulse, and setting takes priority over clearing. Clearing it does not change `rx_done`.
- R8: When `cfg_rts_en`=1, `rts` is 0 while the receiver is idle, enabled and empty. It goes to 1 once a start bit is confirmed and returns to 0 after the character is read with `rx_en`=1. When `cfg_rts_en`=0, `rts` is held at 1.
- R9: With `cfg_par_odd`=0 the data bits plus the parity bit must contain an even number of ones; with `cfg_par_odd`=1 they must contain an odd number. A mismatch sets `par_err` together with the character.
- R10: Any stop bit voted low sets `frm_err` together with the character.
- R11: A character written while `rx_done` is 1 and no read strobe is present sets `ovr_err` and replaces `rx_data`.
- R12: A `buf_rd` pulse clears `rx_done`, `par_err`, `frm_err` and `ovr_err`. Reset clears every flag and forces `rts` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle tick at 16x bit rate |
| rx_en | input | 1 | Reception enable |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_msb_first | input | 1 | Most significant bit first (8-bit only) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_rts_en | input | 1 | Enable ready-to-send signalling |
| buf_rd | input | 1 | Host read strobe for the holding register |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_clr | input | 1 | Software clear of the interrupt request |
| rx_data | output | 8 | Held character |
| rx_done | output | 1 | Receive-complete flag |
| irq_req | output | 1 | Interrupt request |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun flag |
| rts | output | 1 | Ready-to-send, low when ready |

## Verification
The bench sends a two-tick low pulse, which must be rejected as a glitch. A receiver that skipped start validation would clock in a phantom 0xFF character and raise `rts`. It runs both bit orders and both character lengths. A design that applied the most-significant-first order to 7-bit characters, or misplaced them in the byte, returns a permuted value. It corrupts parity and each of the two stop bits separately, so a receiver that checks only the first stop bit misses the second-stop framing error. It also sends two characters without a read and drops the enable in the middle of a character. A design with a wrong overrun rule or a missing abort shows a stale byte, a missing overrun flag or a spurious completion.

// File: rtl/serial_rx_pkg.sv
// Package: shared receiver state encoding.
// Assumes: nothing beyond IEEE 1800-2017.
package serial_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4
    } rx_state_t;
endpackage

// File: rtl/serial_rx_sampler.sv
// Module: serial_rx_sampler
// Synchronises the serial line and takes a three-sample majority vote
// centred on the middle tick of each bit.
// Assumes: OVERSAMPLE is a power of two, at least 8; phase comes from the framer.
module serial_rx_sampler #(
    parameter int OVERSAMPLE = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          rxd_async,
    input  logic [$clog2(OVERSAMPLE)-1:0] phase,
    output logic                          rx_s,
    output logic                          bit_strobe,
    output logic                          bit_val
);
    localparam int PH_W = $clog2(OVERSAMPLE);
    localparam logic [PH_W-1:0] VOTE_A = PH_W'(OVERSAMPLE / 2 - 1);
    localparam logic [PH_W-1:0] VOTE_B = PH_W'(OVERSAMPLE / 2);
    localparam logic [PH_W-1:0] VOTE_C = PH_W'(OVERSAMPLE / 2 + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [1:0]             ones_q;
    logic [2:0]             vote_sum;

    // Purpose: move the asynchronous line into the clock domain, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_async};
    end

    assign rx_s = sync_q[SYNC_STAGES-1];

    // Purpose: count the high samples at the first two voting ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= 2'd0;
        end else if (tick) begin
            if (phase == VOTE_A)      ones_q <= {1'b0, rx_s};
            else if (phase == VOTE_B) ones_q <= ones_q + {1'b0, rx_s};
        end
    end

    assign vote_sum   = {1'b0, ones_q} + {2'b0, rx_s};
    assign bit_strobe = tick && (phase == VOTE_C);
    assign bit_val    = (vote_sum >= 3'd2);

    // R2: the vote count never exceeds two before the third sample
    assert_vote_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase == VOTE_C) |-> (ones_q <= 2'd2));
endmodule

// File: rtl/serial_rx_framer.sv
// Module: serial_rx_framer
// Frame state machine: detects the start edge, validates the start bit,
// shifts data in either order, accumulates parity and checks stop bits.
// Assumes: configuration is stable during a character; OVERSAMPLE is a power of two.
module serial_rx_framer
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_MAX   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          rx_en,
    input  logic                          rx_s,
    input  logic                          bit_strobe,
    input  logic                          bit_val,
    input  logic                          cfg_len_max,
    input  logic                          cfg_msb_first,
    input  logic                          cfg_par_en,
    input  logic                          cfg_par_odd,
    input  logic                          cfg_two_stop,
    output logic [$clog2(OVERSAMPLE)-1:0] phase,
    output logic                          complete,
    output logic [DATA_MAX-1:0]           word,
    output logic                          perr_new,
    output logic                          ferr_new,
    output logic                          start_ok,
    output logic                          idle
);
    localparam int PH_W = $clog2(OVERSAMPLE);
    localparam int NB_W = $clog2(DATA_MAX + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

    rx_state_t           state_q;
    logic [PH_W-1:0]     cnt_q;
    logic [NB_W-1:0]     nbit_q;
    logic                stop_q;
    logic [DATA_MAX-1:0] sh_q;
    logic                par_q;
    logic                perr_q;
    logic                ferr_q;
    logic                prev_q;

    logic            end_tick;
    logic            msb_eff;
    logic            stop_last;
    logic [NB_W-1:0] last_bit;

    assign end_tick  = tick && (cnt_q == PH_LAST);
    assign msb_eff   = cfg_msb_first && cfg_len_max;
    assign stop_last = cfg_two_stop ? stop_q : 1'b1;
    assign last_bit  = cfg_len_max ? NB_W'(DATA_MAX - 1) : NB_W'(DATA_MAX - 2);
    assign phase     = cnt_q;
    assign idle      = (state_q == RX_IDLE);
    assign start_ok  = rx_en && (state_q == RX_START) && bit_strobe && !bit_val;
    assign complete  = rx_en && (state_q == RX_STOP) && bit_strobe && stop_last;
    assign perr_new  = perr_q;
    assign ferr_new  = ferr_q | !bit_val;

    // Purpose: present the character, realigning a short LSB-first character.
    always_comb begin
        if (msb_eff || cfg_len_max) word = sh_q;
        else                        word = {1'b0, sh_q[DATA_MAX-1:1]};
    end

    // Purpose: sequence through the frame, one bit per OVERSAMPLE ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            nbit_q  <= '0;
            stop_q  <= 1'b0;
            sh_q    <= '0;
            par_q   <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            prev_q  <= 1'b1;
        end else begin
            if (tick) prev_q <= rx_s;
            if (!rx_en) begin
                state_q <= RX_IDLE;
                cnt_q   <= '0;
            end else begin
                if (tick && state_q != RX_IDLE) cnt_q <= cnt_q + 1'b1;
                case (state_q)
                    RX_IDLE: begin
                        if (tick && prev_q && !rx_s) begin
                            state_q <= RX_START;
                            cnt_q   <= PH_W'(1);
                            nbit_q  <= '0;
                            stop_q  <= 1'b0;
                            par_q   <= 1'b0;
                            perr_q  <= 1'b0;
                            ferr_q  <= 1'b0;
                        end
                    end
                    RX_START: begin
                        if (bit_strobe && bit_val) begin
                            state_q <= RX_IDLE;
                            cnt_q   <= '0;
                        end else if (end_tick) begin
                            state_q <= RX_DATA;
                        end
                    end
                    RX_DATA: begin
                        if (bit_strobe) begin
                            par_q <= par_q ^ bit_val;
                            if (msb_eff) sh_q <= {sh_q[DATA_MAX-2:0], bit_val};
                            else         sh_q <= {bit_val, sh_q[DATA_MAX-1:1]};
                        end
                        if (end_tick) begin
                            if (nbit_q == last_bit)
                                state_q <= cfg_par_en ? RX_PAR : RX_STOP;
                            else
                                nbit_q <= nbit_q + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (bit_strobe) perr_q <= ((par_q ^ bit_val) != cfg_par_odd);
                        if (end_tick)   state_q <= RX_STOP;
                    end
                    RX_STOP: begin
                        if (bit_strobe) begin
                            ferr_q <= ferr_q | !bit_val;
                            if (stop_last) begin
                                state_q <= RX_IDLE;
                                cnt_q   <= '0;
                            end
                        end else if (end_tick) begin
                            stop_q <= 1'b1;
                        end
                    end
                    default: begin
                        state_q <= RX_IDLE;
                        cnt_q   <= '0;
                    end
                endcase
            end
        end
    end

    // R1: a disabled receiver is idle on the following cycle
    assert_disable_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state_q == RX_IDLE));
    // R3: a start bit voted high returns the receiver to idle
    assert_glitch_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && state_q == RX_START && bit_strobe && bit_val) |=> (state_q == RX_IDLE));
    // R6: completion is followed by idle
    assert_complete_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (state_q == RX_IDLE));
endmodule

// File: rtl/serial_rx_holding.sv
// Module: serial_rx_holding
// Holding register with complete, error and interrupt flags, plus the
// ready-to-send flow control output.
// Assumes: complete and start_ok are single-cycle pulses from the framer.
module serial_rx_holding #(
    parameter int DATA_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                complete,
    input  logic [DATA_MAX-1:0] word,
    input  logic                perr_new,
    input  logic                ferr_new,
    input  logic                start_ok,
    input  logic                idle,
    input  logic                cfg_rts_en,
    input  logic                buf_rd,
    input  logic                irq_ack,
    input  logic                irq_clr,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_done,
    output logic                irq_req,
    output logic                par_err,
    output logic                frm_err,
    output logic                ovr_err,
    output logic                rts
);
    logic busy_q;

    // Purpose: load the character and update complete/error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_done <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
            ovr_err <= 1'b0;
        end else if (complete) begin
            rx_data <= word;
            rx_done <= 1'b1;
            par_err <= (par_err && !buf_rd) | perr_new;
            frm_err <= (frm_err && !buf_rd) | ferr_new;
            ovr_err <= (ovr_err && !buf_rd) | (rx_done && !buf_rd);
        end else if (buf_rd) begin
            rx_done <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
            ovr_err <= 1'b0;
        end
    end

    // Purpose: interrupt request, set on load, cleared by acknowledge or software.
    always_ff @(posedge clk) begin
        if (!rst_n)                  irq_req <= 1'b0;
        else if (complete)           irq_req <= 1'b1;
        else if (irq_ack || irq_clr) irq_req <= 1'b0;
    end

    // Purpose: track whether the receiver can accept another character.
    always_ff @(posedge clk) begin
        if (!rst_n)                     busy_q <= 1'b1;
        else if (start_ok || !rx_en)    busy_q <= 1'b1;
        else if (idle && !rx_done)      busy_q <= 1'b0;
    end

    assign rts = !cfg_rts_en || busy_q;

    // R6: a completed character raises the complete flag
    assert_done_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> rx_done);
    // R7: the request follows every load
    assert_irq_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> irq_req);
    // R7: acknowledge or software clear drops the request
    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!complete && (irq_ack || irq_clr)) |=> !irq_req);
    // R8: a confirmed start bit makes the receiver report busy
    assert_rts_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> rts);
    // R11: loading over an unread character flags overrun
    assert_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && rx_done && !buf_rd) |=> ovr_err);
    // R12: a read with no load in the same cycle empties the holding register
    assert_read_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !complete) |=> (!rx_done && !par_err && !frm_err && !ovr_err));
endmodule

// File: rtl/serial_rx_flow.sv
// Module: serial_rx_flow (top)
// Asynchronous serial receiver with a 16x tick input, configurable framing,
// bit order, parity, holding register flags and ready-to-send output.
// Assumes: tick16 is a single-cycle pulse; configuration is stable per character.
module serial_rx_flow #(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_MAX   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic                rx_en,
    input  logic                rxd,
    input  logic                cfg_len8,
    input  logic                cfg_msb_first,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_stop,
    input  logic                cfg_rts_en,
    input  logic                buf_rd,
    input  logic                irq_ack,
    input  logic                irq_clr,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_done,
    output logic                irq_req,
    output logic                par_err,
    output logic                frm_err,
    output logic                ovr_err,
    output logic                rts
);
    localparam int PH_W = $clog2(OVERSAMPLE);

    logic                rx_s;
    logic                bit_strobe;
    logic                bit_val;
    logic [PH_W-1:0]     phase;
    logic                complete;
    logic [DATA_MAX-1:0] word;
    logic                perr_new;
    logic                ferr_new;
    logic                start_ok;
    logic                idle;

    serial_rx_sampler #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(2)) u_sampler (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd_async(rxd), .phase(phase),
        .rx_s(rx_s), .bit_strobe(bit_strobe), .bit_val(bit_val)
    );

    serial_rx_framer #(.OVERSAMPLE(OVERSAMPLE), .DATA_MAX(DATA_MAX)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_en(rx_en), .rx_s(rx_s),
        .bit_strobe(bit_strobe), .bit_val(bit_val), .cfg_len_max(cfg_len8),
        .cfg_msb_first(cfg_msb_first), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .phase(phase),
        .complete(complete), .word(word), .perr_new(perr_new), .ferr_new(ferr_new),
        .start_ok(start_ok), .idle(idle)
    );

    serial_rx_holding #(.DATA_MAX(DATA_MAX)) u_holding (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .complete(complete), .word(word),
        .perr_new(perr_new), .ferr_new(ferr_new), .start_ok(start_ok), .idle(idle),
        .cfg_rts_en(cfg_rts_en), .buf_rd(buf_rd), .irq_ack(irq_ack), .irq_clr(irq_clr),
        .rx_data(rx_data), .rx_done(rx_done), .irq_req(irq_req), .par_err(par_err),
        .frm_err(frm_err), .ovr_err(ovr_err), .rts(rts)
    );
endmodule

// File: tb/serial_rx_flow_bench.sv
// Bench: directed corner cases plus seeded random characters.
module serial_rx_flow_bench;
    localparam int BITCLK = 64; // 16 ticks of 4 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic tick16;
    logic rx_en = 1'b0, rxd = 1'b1;
    logic cfg_len8 = 1'b1, cfg_msb_first = 1'b0, cfg_par_en = 1'b0;
    logic cfg_par_odd = 1'b0, cfg_two_stop = 1'b0, cfg_rts_en = 1'b1;
    logic buf_rd = 1'b0, irq_ack = 1'b0, irq_clr = 1'b0;
    logic [7:0] rx_data;
    logic rx_done, irq_req, par_err, frm_err, ovr_err, rts;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick16 = (tdiv == 2'd3);

    serial_rx_flow u_serial_rx_flow (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en), .rxd(rxd),
        .cfg_len8(cfg_len8), .cfg_msb_first(cfg_msb_first), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .cfg_rts_en(cfg_rts_en),
        .buf_rd(buf_rd), .irq_ack(irq_ack), .irq_clr(irq_clr), .rx_data(rx_data),
        .rx_done(rx_done), .irq_req(irq_req), .par_err(par_err), .frm_err(frm_err),
        .ovr_err(ovr_err), .rts(rts)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_word(input logic [7:0] d, input bit len8);
        return len8 ? d : {1'b0, d[6:0]};
    endfunction

    function automatic bit line_bit(input logic [7:0] d, input bit len8, input bit msb, input int i);
        return (len8 && msb) ? d[7 - i] : d[i];
    endfunction

    function automatic bit par_bit(input logic [7:0] d, input bit len8, input bit odd);
        return (^exp_word(d, len8)) ^ odd;
    endfunction

    task automatic send_bit(input bit v);
        rxd = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        if (which == 0) buf_rd = 1'b1;
        else if (which == 1) irq_ack = 1'b1;
        else irq_clr = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0; irq_ack = 1'b0; irq_clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Sends one character with the current configuration; optional corruption.
    task automatic send_char(input logic [7:0] d, input bit bad_par, input bit bad_s1, input bit bad_s2);
        int n = cfg_len8 ? 8 : 7;
        send_bit(1'b0);
        for (int i = 0; i < n; i++) begin
            send_bit(line_bit(d, cfg_len8, cfg_msb_first, i));
            if (i == 1 && cfg_rts_en) chk("R8 rts busy during char", rts, 1);
        end
        if (cfg_par_en) send_bit(par_bit(d, cfg_len8, cfg_par_odd) ^ bad_par);
        send_bit(!bad_s1);
        if (cfg_two_stop) send_bit(!bad_s2);
        send_bit(1'b1);
    endtask

    // Full check of one character then clear it.
    task automatic run_char(input logic [7:0] d, input bit bad_par, input bit bad_s1,
                            input bit bad_s2, input int clr_kind);
        send_char(d, bad_par, bad_s1, bad_s2);
        chk("R6 done set", rx_done, 1);
        chk("R5 R4 data", rx_data, exp_word(d, cfg_len8));
        chk("R9 parity flag", par_err, cfg_par_en && bad_par);
        chk("R10 framing flag", frm_err, bad_s1 || (cfg_two_stop && bad_s2));
        chk("R11 no overrun", ovr_err, 0);
        chk("R7 irq set", irq_req, 1);
        chk("R8 rts held until read", rts, 1);
        pulse(clr_kind);
        chk("R7 irq cleared", irq_req, 0);
        chk("R7 done unaffected by irq clear", rx_done, 1);
        pulse(0);
        chk("R12 read clears done", rx_done, 0);
        chk("R12 read clears errors", {par_err, frm_err, ovr_err}, 0);
        chk("R8 rts ready after read", rts, !cfg_rts_en);
    endtask

    initial begin
        void'($urandom(32'h1f3a_5c07));
        repeat (5) @(negedge clk);
        chk("R12 reset rts", rts, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 reset flags", {rx_done, irq_req, par_err, frm_err, ovr_err}, 0);

        // R1: disabled receiver ignores a full character
        send_char(8'h3C, 0, 0, 0);
        chk("R1 ignored while disabled", rx_done, 0);
        chk("R8 rts high while disabled", rts, 1);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 rts ready when idle", rts, 0);

        // R3: two-tick glitch rejected
        rxd = 1'b0; repeat (8) @(negedge clk);
        rxd = 1'b1; repeat (3 * BITCLK) @(negedge clk);
        chk("R3 glitch no char", rx_done, 0);
        chk("R3 glitch rts unchanged", rts, 0);

        // R4 R5: 8-bit LSB first, MSB first, 7-bit with msb select ignored
        run_char(8'hA1, 0, 0, 0, 1);
        cfg_msb_first = 1'b1;
        run_char(8'hA1, 0, 0, 0, 2);
        cfg_len8 = 1'b0;
        run_char(8'hD3, 0, 0, 0, 1);
        cfg_len8 = 1'b1; cfg_msb_first = 1'b0;

        // R9: parity even and odd, good and bad
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        run_char(8'h5B, 0, 0, 0, 1);
        run_char(8'h5B, 1, 0, 0, 1);
        cfg_par_odd = 1'b1;
        run_char(8'h80, 1, 0, 0, 2);
        cfg_par_en = 1'b0;

        // R10: bad first stop, bad second stop
        run_char(8'h0F, 0, 1, 0, 1);
        cfg_two_stop = 1'b1;
        run_char(8'hF0, 0, 0, 1, 2);
        cfg_two_stop = 1'b0;

        // R11: two characters with no read
        send_char(8'h11, 0, 0, 0);
        send_char(8'h22, 0, 0, 0);
        chk("R11 overrun set", ovr_err, 1);
        chk("R11 data replaced", rx_data, 8'h22);
        pulse(0);
        chk("R12 read clears overrun", ovr_err, 0);

        // R1: enable dropped mid character
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        rx_en = 1'b0;
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        rx_en = 1'b1;
        repeat (BITCLK) @(negedge clk);
        chk("R1 aborted char not loaded", rx_done, 0);

        // R8: flow control disabled holds rts high
        cfg_rts_en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 rts disabled high", rts, 1);
        cfg_rts_en = 1'b1;

        // R2 R4 R9 R10: random configurations and data
        for (int k = 0; k < 24; k++) begin
            logic [31:0] r = $urandom;
            cfg_len8 = r[0]; cfg_msb_first = r[1]; cfg_par_en = r[2];
            cfg_par_odd = r[3]; cfg_two_stop = r[4];
            run_char(r[15:8], r[16] & r[17], r[18] & r[19], r[20] & r[21], 1 + int'(r[22]));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule